// File: doc/BRIEF.md
# Single-Channel Bus-Mastering DMA Controller

This block copies a block of bytes between one I/O device and memory so that the CPU never carries the data itself. Software sets a memory start address and a byte count, then writes a control word. That word gives the transfer direction and the transfer mode, and a start bit launches the transfer. The controller asks the CPU for the system bus on `br` and waits for `bg`. It then drives the memory address and strobes on its own, two bus phases per byte, until the count reaches zero.

Three modes decide when the bus request is released. Burst keeps the request up for the whole block. Cycle stealing moves one byte per grant and lets the bus go between bytes. Bus-idle moves a byte only after a cycle in which the CPU has flagged, on `cpu_idle`, that it is not using the bus.

The control state machine has five states:
- ST_IDLE: no request.
- ST_REQ: request raised, waiting for the grant.
- ST_FIRST: first strobe of a byte.
- ST_SECOND: second strobe of a byte; the address and count step here.
- ST_GAP: one cycle with the request released, used only in cycle stealing.

Its transitions are:
- ST_IDLE to ST_REQ on an accepted start with a non-zero count.
- ST_REQ to ST_FIRST when `bg` is high. In bus-idle mode `cpu_idle` must also be high.
- ST_FIRST to ST_SECOND always.
- ST_SECOND to ST_IDLE on the last byte.
- ST_SECOND to ST_GAP in cycle stealing.
- ST_SECOND to ST_REQ otherwise.
- ST_GAP to ST_REQ always.

Top module: `dma_chan`

## Requirements
- R1: After reset `br`, `dack`, `mem_rd` and `mem_wr` are low. The status word (select 3) reads 0 and `mem_addr` is 0.
- R2: A write with `io_sel` selects a register:
  - 0 loads the memory start address.
  - 1 loads the byte count.
  - 2 loads the control word: bit 0 direction (0 device to memory, 1 memory to device), bits 2:1 mode (0 burst, 1 cycle stealing, 2 bus-idle, 3 acts as burst), bit 3 start.
  - Reads of select 0 and 1 return the current address and remaining count. Select 3 returns status: bit 0 busy, bit 1 done.
- R3: An accepted start raises busy and (outside bus-idle mode) `br` in the following cycle. No strobe occurs and the count does not change while `bg` is low.
- R4: Each byte uses two single-strobe phases. Direction 0 pulses `dack` (device byte captured), then `mem_wr` with that byte on `mem_wdata`. Direction 1 pulses `mem_rd` (byte captured from `mem_rdata`), then `dack` with that byte on `dev_wdata`.
- R5: After each byte the address rises by one and the count falls by one. After the last byte busy clears, done sets and `br` drops.
- R6: In burst mode `br` stays high from the start until the last byte, giving one request per block.
- R7: In cycle-stealing mode `br` is low in the cycle after every byte, giving one request per byte.
- R8: In bus-idle mode, while waiting, `br` follows `cpu_idle`. A byte's first strobe occurs only in the cycle after one where both `bg` and `cpu_idle` were high.
- R9: While busy, writes to the address, count and control registers are ignored, including a start.
- R10: A start with a count of zero sets done in the same write cycle. It leaves busy clear and never raises `br`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | CPU port write strobe |
| io_sel | input | 2 | CPU port register select |
| io_wdata | input | ADDR_W | CPU port write data |
| io_rdata | output | ADDR_W | CPU port read data for the selected register |
| br | output | 1 | Bus request to the CPU |
| bg | input | 1 | Bus grant from the CPU |
| cpu_idle | input | 1 | CPU is in a state that leaves the bus free |
| mem_addr | output | ADDR_W | Memory address of the current byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Byte written to memory |
| mem_rdata | input | DATA_W | Byte read from memory |
| dack | output | 1 | Device-side strobe for one byte |
| dev_rdata | input | DATA_W | Byte offered by the device |
| dev_wdata | output | DATA_W | Byte delivered to the device |

## Verification
A wrong state in the sequencer shows on the strobes in the cycle it occurs. Examples are a swapped phase order, a strobe without grant, or a missing release cycle in cycle stealing. A wrong address or count step shows as a misplaced byte in memory and a wrong read-back once the block ends, a few cycles later. A dropped ignore on a busy write shows as a block landing at the wrong address or in the wrong direction. A zero-count start that requests the bus shows on `br` in the next cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_FIRST,
        ST_SECOND,
        ST_GAP
    } dma_state_e;

    localparam logic [1:0] SEL_ADDR   = 2'd0;
    localparam logic [1:0] SEL_COUNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

    localparam int CTL_DIR     = 0;
    localparam int CTL_MODE_LO = 1;
    localparam int CTL_START   = 3;

    localparam logic [1:0] MODE_BURST = 2'd0;
    localparam logic [1:0] MODE_STEAL = 2'd1;
    localparam logic [1:0] MODE_IDLE  = 2'd2;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [1:0]        io_sel,
    input  logic [ADDR_W-1:0] io_wdata,
    output logic [ADDR_W-1:0] io_rdata,
    input  logic              busy,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_q,
    output logic              dir_q,
    output logic [1:0]        mode_q,
    output logic              go,
    output logic              last
);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             wr_addr;
    logic             wr_cnt;
    logic             wr_ctrl;
    logic             start_req;
    logic             zero_start;

    assign wr_addr    = io_wr && (io_sel == SEL_ADDR)  && !busy;
    assign wr_cnt     = io_wr && (io_sel == SEL_COUNT) && !busy;
    assign wr_ctrl    = io_wr && (io_sel == SEL_CTRL)  && !busy;
    assign start_req  = wr_ctrl && io_wdata[CTL_START];
    assign go         = start_req && (cnt_q != '0);
    assign zero_start = start_req && (cnt_q == '0);
    assign last       = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            mode_q <= MODE_BURST;
            done_q <= 1'b0;
        end else begin
            if (wr_addr) begin
                addr_q <= io_wdata;
            end else if (step) begin
                addr_q <= addr_q + ADDR_W'(1);
            end
            if (wr_cnt) begin
                cnt_q <= io_wdata[CNT_W-1:0];
            end else if (step) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (wr_ctrl) begin
                dir_q  <= io_wdata[CTL_DIR];
                mode_q <= io_wdata[CTL_MODE_LO +: 2];
            end
            if (go) begin
                done_q <= 1'b0;
            end else if (zero_start || (step && last)) begin
                done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (io_sel)
            SEL_ADDR:   io_rdata = addr_q;
            SEL_COUNT:  io_rdata = ADDR_W'(cnt_q);
            SEL_CTRL:   io_rdata = ADDR_W'({mode_q, dir_q});
            SEL_STATUS: io_rdata = ADDR_W'({done_q, busy});
            default:    io_rdata = '0;
        endcase
    end

    // R9: a register write arriving while a block is in flight changes nothing
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && io_wr && (io_sel == SEL_ADDR) && !step) |=> $stable(addr_q));

    a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && io_wr && (io_sel == SEL_CTRL)) |=> ($stable(dir_q) && $stable(mode_q)));

    // R10: zero-length start completes without the sequencer leaving idle
    a_r10_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (io_sel == SEL_CTRL) && io_wdata[CTL_START] && !busy && (cnt_q == '0))
        |=> (done_q && !busy));

    // R5: the final byte empties the count and flags completion
    a_r5_count_end: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> ((cnt_q == '0) && done_q && !busy));

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       last,
    input  logic       dir,
    input  logic [1:0] mode,
    input  logic       bg,
    input  logic       cpu_idle,
    output logic       busy,
    output logic       step,
    output logic       capture,
    output logic       br,
    output logic       dack,
    output logic       mem_rd,
    output logic       mem_wr
);

    dma_state_e state_q;
    dma_state_e state_d;
    logic       is_steal;
    logic       is_idle_mode;
    logic       may_take;

    assign is_steal     = (mode == MODE_STEAL);
    assign is_idle_mode = (mode == MODE_IDLE);
    assign may_take     = !is_idle_mode || cpu_idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_REQ;
            ST_REQ:    if (bg && may_take) state_d = ST_FIRST;
            ST_FIRST:  state_d = ST_SECOND;
            ST_SECOND: begin
                if (last)          state_d = ST_IDLE;
                else if (is_steal) state_d = ST_GAP;
                else               state_d = ST_REQ;
            end
            ST_GAP:    state_d = ST_REQ;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        br      = 1'b0;
        dack    = 1'b0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        step    = 1'b0;
        capture = 1'b0;
        busy    = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  br = may_take;
            ST_FIRST: begin
                br      = 1'b1;
                capture = 1'b1;
                if (dir) mem_rd = 1'b1;
                else     dack   = 1'b1;
            end
            ST_SECOND: begin
                br   = 1'b1;
                step = 1'b1;
                if (dir) dack   = 1'b1;
                else     mem_wr = 1'b1;
            end
            ST_GAP:  ;
            default: ;
        endcase
    end

    // R4: never more than one bus strobe in a cycle
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dack, mem_rd, mem_wr}));

    // R3: strobes only while the bus is requested and granted
    a_r3_strobe_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (dack || mem_rd || mem_wr) |-> (bg && br));

    // R7: cycle stealing lets the bus go right after every byte
    a_r7_release_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (step && is_steal) |=> !br);

    // R6: burst holds the request for the whole block
    a_r6_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_steal && !is_idle_mode) |-> br);

    // R4: second phase always directly follows the first
    a_r4_phase_pair: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> step);

endmodule

// File: rtl/dma_chan_data.sv
module dma_chan_data #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              dir,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] dev_wdata
);

    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (capture) begin
            byte_q <= dir ? mem_rdata : dev_rdata;
        end
    end

    assign mem_wdata = byte_q;
    assign dev_wdata = byte_q;

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [1:0]        io_sel,
    input  logic [ADDR_W-1:0] io_wdata,
    output logic [ADDR_W-1:0] io_rdata,
    output logic              br,
    input  logic              bg,
    input  logic              cpu_idle,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dack,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] dev_wdata
);

    logic       busy;
    logic       step;
    logic       capture;
    logic       go;
    logic       last;
    logic       dir;
    logic [1:0] mode;

    dma_chan_regs #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_sel  (io_sel),
        .io_wdata(io_wdata),
        .io_rdata(io_rdata),
        .busy    (busy),
        .step    (step),
        .addr_q  (mem_addr),
        .dir_q   (dir),
        .mode_q  (mode),
        .go      (go),
        .last    (last)
    );

    dma_chan_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .last    (last),
        .dir     (dir),
        .mode    (mode),
        .bg      (bg),
        .cpu_idle(cpu_idle),
        .busy    (busy),
        .step    (step),
        .capture (capture),
        .br      (br),
        .dack    (dack),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr)
    );

    dma_chan_data #(
        .DATA_W(DATA_W)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .dir      (dir),
        .dev_rdata(dev_rdata),
        .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata),
        .dev_wdata(dev_wdata)
    );

    // R5: every completed byte moves the memory address on by one
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (mem_addr == ($past(mem_addr) + ADDR_W'(1))));

endmodule

// File: tb/dma_chan_bench.sv
`timescale 1ns/1ps
module dma_chan_bench;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              io_wr = 1'b0;
    logic [1:0]        io_sel = 2'd3;
    logic [ADDR_W-1:0] io_wdata = '0;
    logic [ADDR_W-1:0] io_rdata;
    logic              br;
    logic              bg = 1'b0;
    logic              cpu_idle = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd, mem_wr, dack;
    logic [DATA_W-1:0] mem_wdata, mem_rdata, dev_rdata, dev_wdata;

    always #2 clk = ~clk;

    dma_chan u_dma_chan (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .br(br), .bg(bg),
        .cpu_idle(cpu_idle), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dack(dack), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
    );

    // memory and device models
    logic [7:0] mem  [0:255];
    logic [7:0] src  [0:15];
    logic [7:0] sink [0:15];
    int         dev_idx = 0;
    logic       dev_clr = 1'b0;
    logic       cur_dir = 1'b0;
    int         cur_mode = 0;
    logic       hold_grant = 1'b0;
    logic       idle_rand = 1'b0;
    logic       idle_force = 1'b1;

    assign mem_rdata = mem[mem_addr[7:0]];
    assign dev_rdata = src[dev_idx[3:0]];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (dev_clr) begin
            dev_idx <= 0;
        end else if (dack) begin
            if (cur_dir) sink[dev_idx[3:0]] <= dev_wdata;
            dev_idx <= dev_idx + 1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n || !br)                                  bg <= 1'b0;
        else if (!bg && !hold_grant && $urandom_range(2) == 0) bg <= 1'b1;
        cpu_idle <= idle_rand ? 1'($urandom_range(1)) : idle_force;
    end

    // protocol monitor, sampled away from the active edge
    int   grant_err, order_err, gap_err, idle_err, bytes_seen, br_rises;
    logic expect_first, gap_pending, p_br, p_bg, p_idle;

    always @(negedge clk) begin : mon
        logic fk, sk;
        if (rst_n) begin
            fk = cur_dir ? mem_rd : dack;
            sk = cur_dir ? dack : mem_wr;
            if ((dack || mem_rd || mem_wr) && !bg) grant_err++;
            if (gap_pending) begin
                if (br) gap_err++;
                gap_pending = 1'b0;
            end
            if (fk) begin
                if (!expect_first) order_err++;
                expect_first = 1'b0;
                if (cur_mode == 2 && !(p_bg && p_idle)) idle_err++;
            end
            if (sk) begin
                if (expect_first) order_err++;
                expect_first = 1'b1;
                bytes_seen++;
                if (cur_mode == 1) gap_pending = 1'b1;
            end
            if (br && !p_br) br_rises++;
            p_br = br;
            p_bg = bg;
            p_idle = cpu_idle;
        end
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_rises(input int mode, input int cnt);
        if (mode == 1) return cnt;
        return 1;
    endfunction

    function automatic int ctrl_word(input int mode, input bit dir, input bit start);
        return (int'(start) << 3) | ((mode & 3) << 1) | int'(dir);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic io_write(input logic [1:0] sel, input int val);
        @(posedge clk); #1;
        io_wr = 1'b1; io_sel = sel; io_wdata = ADDR_W'(val);
        @(posedge clk); #1;
        io_wr = 1'b0; io_sel = 2'd3;
    endtask

    task automatic io_read(input logic [1:0] sel, output int val);
        @(posedge clk); #1;
        io_sel = sel;
        @(negedge clk);
        val = int'(io_rdata);
        #1 io_sel = 2'd3;
    endtask

    task automatic clear_mon();
        grant_err = 0; order_err = 0; gap_err = 0; idle_err = 0;
        bytes_seen = 0; br_rises = 0;
        expect_first = 1'b1; gap_pending = 1'b0;
    endtask

    task automatic start_xfer(input int mode, input bit dir, input int addr, input int cnt);
        for (int i = 0; i < 16; i++) begin
            src[i] = 8'($urandom);
            sink[i] = 8'h00;
        end
        for (int i = 0; i < cnt; i++) begin
            mem[(addr + i) & 255] = dir ? 8'($urandom) : 8'h00;
        end
        @(posedge clk); #1; dev_clr = 1'b1;
        @(posedge clk); #1; dev_clr = 1'b0;
        cur_dir = dir; cur_mode = mode;
        io_write(2'd0, addr);
        io_write(2'd1, cnt);
        clear_mon();
        io_write(2'd2, ctrl_word(mode, dir, 1'b1));
    endtask

    task automatic wait_idle();
        int st;
        for (int k = 0; k < 4000; k++) begin
            io_read(2'd3, st);
            if ((st & 1) == 0) return;
        end
        check(1'b0, "R5 block never finished", 1, 0);
    endtask

    task automatic finish_xfer(input int mode, input bit dir, input int addr, input int cnt);
        int v;
        int bad;
        wait_idle();
        tick(2);
        bad = 0;
        for (int i = 0; i < cnt; i++) begin
            if (dir == 1'b0 && mem[(addr + i) & 255] != src[i]) bad++;
            if (dir == 1'b1 && sink[i] != mem[(addr + i) & 255]) bad++;
        end
        check(bad == 0, "R4 block data", bad, 0);
        check(order_err == 0, "R4 phase order", order_err, 0);
        check(bytes_seen == cnt, "R4 byte count", bytes_seen, cnt);
        check(grant_err == 0, "R3 strobe without grant", grant_err, 0);
        io_read(2'd0, v);
        check(v == addr + cnt, "R5 final address", v, addr + cnt);
        io_read(2'd1, v);
        check(v == 0, "R5 final count", v, 0);
        io_read(2'd3, v);
        check(v == 2, "R5 status done", v, 2);
        check(br == 1'b0, "R5 br released", int'(br), 0);
        if (mode != 2) begin
            check(br_rises == exp_rises(mode, cnt),
                  (mode == 1) ? "R7 request per byte" : "R6 request per block",
                  br_rises, exp_rises(mode, cnt));
        end
        if (mode == 1) check(gap_err == 0, "R7 release gap", gap_err, 0);
        if (mode == 2) check(idle_err == 0, "R8 idle gating", idle_err, 0);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int v;
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < 16; i++) begin
            src[i] = 8'h00;
            sink[i] = 8'h00;
        end
        clear_mon();
        p_br = 1'b0; p_bg = 1'b0; p_idle = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        @(negedge clk);
        check({br, dack, mem_rd, mem_wr} == 4'b0, "R1 strobes after reset",
              int'({br, dack, mem_rd, mem_wr}), 0);
        check(mem_addr == 0, "R1 address after reset", int'(mem_addr), 0);
        io_read(2'd3, v);
        check(v == 0, "R1 status after reset", v, 0);

        // R10 zero count
        clear_mon();
        io_write(2'd1, 0);
        io_write(2'd2, ctrl_word(0, 1'b0, 1'b1));
        io_read(2'd3, v);
        check(v == 2, "R10 zero count done", v, 2);
        tick(10);
        check(br_rises == 0, "R10 no request", br_rises, 0);

        // R2 read-back of programmed registers
        io_write(2'd0, 16'h1234);
        io_write(2'd1, 16'h0007);
        io_write(2'd2, ctrl_word(2, 1'b1, 1'b0));
        io_read(2'd0, v);
        check(v == 16'h1234, "R2 address read-back", v, 16'h1234);
        io_read(2'd1, v);
        check(v == 7, "R2 count read-back", v, 7);
        io_read(2'd2, v);
        check(v == 5, "R2 control read-back", v, 5);

        // R3 held grant, burst, device to memory
        hold_grant = 1'b1;
        start_xfer(0, 1'b0, 16'h10, 5);
        @(negedge clk);
        check(br == 1'b1, "R3 request after start", int'(br), 1);
        tick(20);
        check(bytes_seen == 0, "R3 no strobe without grant", bytes_seen, 0);
        io_read(2'd1, v);
        check(v == 5, "R3 count frozen", v, 5);
        io_read(2'd3, v);
        check(v == 1, "R3 busy", v, 1);
        hold_grant = 1'b0;
        finish_xfer(0, 1'b0, 16'h10, 5);

        // R7 cycle stealing, memory to device
        start_xfer(1, 1'b1, 16'h40, 4);
        finish_xfer(1, 1'b1, 16'h40, 4);

        // R8 bus-idle mode with the CPU busy at first
        idle_force = 1'b0;
        start_xfer(2, 1'b0, 16'h60, 5);
        tick(25);
        check(bytes_seen == 0, "R8 no byte while CPU busy", bytes_seen, 0);
        check(br_rises == 0, "R8 br follows cpu_idle", br_rises, 0);
        idle_rand = 1'b1;
        finish_xfer(2, 1'b0, 16'h60, 5);
        idle_rand = 1'b0;
        idle_force = 1'b1;

        // R9 writes while busy ignored
        start_xfer(1, 1'b0, 16'h80, 6);
        tick(6);
        io_write(2'd2, ctrl_word(0, 1'b1, 1'b1));
        io_write(2'd0, 16'h99);
        io_write(2'd1, 1);
        finish_xfer(1, 1'b0, 16'h80, 6);
        check(mem[8'h99] == 8'h00, "R9 no write at ignored address", int'(mem[8'h99]), 0);

        // random blocks
        for (int it = 0; it < 8; it++) begin
            int m, a, c;
            bit d;
            m = $urandom_range(2);
            d = 1'($urandom_range(1));
            a = $urandom_range(200);
            c = 1 + $urandom_range(7);
            idle_rand = (m == 2);
            start_xfer(m, d, a, c);
            finish_xfer(m, d, a, c);
        end
        idle_rand = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule